// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This unit sits between a core's register file and its data memory. It serves single-register transfers. For each request it forms the effective address from a base value and an offset, issues one memory access, and reports the updated base value for writeback. The offset can be a zero-extended immediate, a register value, or a register value shifted left by an immediate amount. The offset is either added to the base or subtracted from it.

Three indexing behaviours are supported:
- Pre-index leaves the base untouched.
- Pre-index with update writes the computed address back to the base.
- Post-index accesses memory at the unmodified base and then writes the computed address back.

Memory is byte addressed and little-endian. The unit places store data on the correct byte lanes, together with matching byte enables. It extracts load data from the right lanes and zero- or sign-extends it. Misaligned halfword and word accesses are rejected with a one-cycle fault pulse, and no memory request is issued for them.

The unit handles one request at a time. A request is taken when `reqValid` is high while `reqReady` is high. The memory side then holds `memValid` and its request fields until `memReady` is seen high. In that same cycle the unit produces the load result and the writeback strobe, both combinationally.

Top module: `lsu_unit`

## Requirements
- R1: The effective address is `baseVal + offset` when `addOffset` is 1 and `baseVal - offset` when it is 0, modulo 2^32. The immediate offset is `immOffset`, zero-extended.
- R2: `offSel` encoding: 2'b00 selects the immediate. 2'b01 selects `regOffset` as is. 2'b10 and 2'b11 select `regOffset` shifted left by `shiftAmt`.
- R3: With `preIndex`=1 and `writeBack`=0, the access uses the effective address and `baseWe` never rises for that request.
- R4: With `preIndex`=1 and `writeBack`=1, the access uses the effective address. `baseWe` pulses with `baseNew` equal to that address.
- R5: With `preIndex`=0, the access uses the unmodified base. `baseWe` pulses with `baseNew` equal to the effective address, and `writeBack` is ignored.
- R6: `accSize` encoding: 2'b00 byte, 2'b01 halfword, 2'b1x word. On a store, the low 1, 2 or 4 bytes of `storeData` appear on the lanes starting at lane `memAddr[1:0]`. Exactly those bits of `memByteEn` are set (bit i is lane i, bits 8i+7..8i), and `memWrite` is 1.
- R7: On a load, the selected lanes of `memRdata` are returned on `loadData` while `memReady` is high. Lane `memAddr[1:0]` becomes bit 0. Byte and halfword loads are zero-extended, or sign-extended when `signedLoad` is 1. `signedLoad` has no effect on word loads.
- R8: A halfword request with address bit 0 set, or a word request with non-zero address bits [1:0], pulses `alignFault` for one cycle, starting the cycle after acceptance. No memory request is issued for it, and the unit is ready again in that cycle.
- R9: While `memValid` is high and `memReady` is low, `memValid`, `memAddr`, `memByteEn`, `memWdata` and `memWrite` stay stable and `baseWe` stays low. `baseWe` is only ever high together with `memValid` and `memReady`.
- R10: While a request is outstanding, `reqReady` is low and `reqValid` and the request inputs are ignored.
- R11: After reset, `reqReady` is 1 and `memValid`, `baseWe`, `loadValid` and `alignFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit idle, request will be taken |
| baseVal | input | 32 | Base register value |
| immOffset | input | 12 | Immediate offset, zero-extended |
| regOffset | input | 32 | Register offset value |
| offSel | input | 2 | Offset source select |
| shiftAmt | input | 5 | Left-shift amount for register offset |
| preIndex | input | 1 | 1: access at effective address, 0: access at base |
| writeBack | input | 1 | Update base in pre-index mode |
| addOffset | input | 1 | 1: add offset, 0: subtract |
| accSize | input | 2 | Access size |
| signedLoad | input | 1 | Sign-extend sub-word load |
| isStore | input | 1 | 1: store, 0: load |
| storeData | input | 32 | Store source register value |
| memValid | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts/completes request |
| memAddr | output | 32 | Access byte address |
| memByteEn | output | 4 | Byte lane enables |
| memWrite | output | 1 | Request is a write |
| memWdata | output | 32 | Lane-aligned write data |
| memRdata | input | 32 | Read data, valid with memReady |
| loadData | output | 32 | Aligned, extended load result |
| loadValid | output | 1 | Load result valid this cycle |
| alignFault | output | 1 | Misaligned request rejected |
| baseNew | output | 32 | Updated base value |
| baseWe | output | 1 | Base writeback strobe |

## Verification
The bench builds the unit with its default parameters: 32-bit address and data, a 12-bit immediate and a 5-bit shift amount. With these, every lane position can be reached for byte, halfword and word accesses. Subtraction that wraps below the base can be reached, and so can a shifted register offset. The bench puts stall cycles of varying length between issue and response. During those stalls it presents a second request with different inputs, to show the outstanding access neither changes nor updates the base early.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } accSize_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } lsuState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch a new aligned request
    logic busy;      // request outstanding
    logic respTake;  // memory response accepted this cycle
  } lsuCtrl_t;
endpackage

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHIFT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  lsuCtrl_t             ctrl,
  input  logic [ADDR_W-1:0]    baseVal,
  input  logic [IMM_W-1:0]     immOffset,
  input  logic [ADDR_W-1:0]    regOffset,
  input  logic [1:0]           offSel,
  input  logic [SHIFT_W-1:0]   shiftAmt,
  input  logic                 preIndex,
  input  logic                 writeBack,
  input  logic                 addOffset,
  input  logic [1:0]           accSize,
  input  logic                 signedLoad,
  input  logic                 isStore,
  input  logic [DATA_W-1:0]    storeData,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 misaligned,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W/8-1:0]  memByteEn,
  output logic                 memWrite,
  output logic [DATA_W-1:0]    memWdata,
  output logic [DATA_W-1:0]    loadData,
  output logic                 loadValid,
  output logic [ADDR_W-1:0]    baseNew,
  output logic                 baseWe
);
  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);

  logic [ADDR_W-1:0] offset, effAddr, reqAddr;
  logic [1:0]        sizeEff;
  logic [LB-1:0]     lo;
  logic [LANES-1:0]  beNext;
  logic [DATA_W-1:0] wdNext;

  // offset source and effective address
  always_comb begin
    if (offSel[1])      offset = regOffset << shiftAmt;
    else if (offSel[0]) offset = regOffset;
    else                offset = ADDR_W'(immOffset);
    effAddr = addOffset ? baseVal + offset : baseVal - offset;
    reqAddr = preIndex ? effAddr : baseVal;
    sizeEff = accSize[1] ? SZ_WORD : accSize;
    lo      = reqAddr[LB-1:0];
  end

  assign misaligned = |(lo & LB'((1 << sizeEff) - 1));

  // lane placement for stores
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      beNext[i]          = (i >= int'(lo)) && (i < int'(lo) + (1 << sizeEff));
      wdNext[8*i +: 8]   = storeData[8*(i % (1 << sizeEff)) +: 8];
    end
  end

  logic [1:0] sizeQ;
  logic       signQ, storeQ, wbQ;
  logic [ADDR_W-1:0] newBaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memByteEn <= '0;
      memWdata  <= '0;
      storeQ    <= 1'b0;
      sizeQ     <= SZ_BYTE;
      signQ     <= 1'b0;
      wbQ       <= 1'b0;
      newBaseQ  <= '0;
    end else if (ctrl.capture) begin
      memAddr   <= reqAddr;
      memByteEn <= beNext;
      memWdata  <= wdNext;
      storeQ    <= isStore;
      sizeQ     <= sizeEff;
      signQ     <= signedLoad;
      wbQ       <= writeBack | ~preIndex;
      newBaseQ  <= effAddr;
    end
  end

  // load alignment and extension
  logic [DATA_W-1:0] shifted;
  always_comb begin
    shifted = memRdata >> {memAddr[LB-1:0], 3'b000};
    unique case (sizeQ)
      SZ_BYTE: loadData = {{(DATA_W-8){signQ & shifted[7]}}, shifted[7:0]};
      SZ_HALF: loadData = {{(DATA_W-16){signQ & shifted[15]}}, shifted[15:0]};
      default: loadData = shifted;
    endcase
  end

  assign memWrite  = storeQ;
  assign baseNew   = newBaseQ;
  assign baseWe    = ctrl.respTake & wbQ;
  assign loadValid = ctrl.respTake & ~storeQ;

  // R7: signed byte load result carries its sign through the upper bits
  p_sext_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && sizeQ == SZ_BYTE && signQ) |->
      (loadData[DATA_W-1:8] == {(DATA_W-8){loadData[7]}}));

  // R6: enabled lane count matches access size while request is out
  p_be_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.busy |-> ($countones(memByteEn) == (1 << sizeQ)));
endmodule

// File: rtl/lsu_control.sv
module lsu_control
  import lsu_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     misaligned,
  input  logic     memReady,
  output lsuCtrl_t ctrl,
  output logic     reqReady,
  output logic     memValid,
  output logic     alignFault
);
  lsuState_e state;

  assign reqReady      = (state == ST_IDLE);
  assign memValid      = (state == ST_BUSY);
  assign ctrl.capture  = reqReady & reqValid & ~misaligned;
  assign ctrl.busy     = memValid;
  assign ctrl.respTake = memValid & memReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      alignFault <= 1'b0;
    end else begin
      alignFault <= reqReady & reqValid & misaligned;
      if (ctrl.capture)       state <= ST_BUSY;
      else if (ctrl.respTake) state <= ST_IDLE;
    end
  end

  // R8: a rejected request never produces a memory request
  p_fault_noreq_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !memValid);

  // R10: no new request is offered while one is outstanding
  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !reqReady);
endmodule

// File: rtl/lsu_unit.sv
module lsu_unit
  import lsu_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHIFT_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   baseVal,
  input  logic [IMM_W-1:0]    immOffset,
  input  logic [ADDR_W-1:0]   regOffset,
  input  logic [1:0]          offSel,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  input  logic                preIndex,
  input  logic                writeBack,
  input  logic                addOffset,
  input  logic [1:0]          accSize,
  input  logic                signedLoad,
  input  logic                isStore,
  input  logic [DATA_W-1:0]   storeData,
  output logic                memValid,
  input  logic                memReady,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W/8-1:0] memByteEn,
  output logic                memWrite,
  output logic [DATA_W-1:0]   memWdata,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W-1:0]   loadData,
  output logic                loadValid,
  output logic                alignFault,
  output logic [ADDR_W-1:0]   baseNew,
  output logic                baseWe
);
  lsuCtrl_t ctrl;
  logic     misaligned;

  lsu_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .misaligned(misaligned),
    .memReady(memReady), .ctrl(ctrl), .reqReady(reqReady),
    .memValid(memValid), .alignFault(alignFault)
  );

  lsu_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .SHIFT_W(SHIFT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .baseVal(baseVal),
    .immOffset(immOffset), .regOffset(regOffset), .offSel(offSel),
    .shiftAmt(shiftAmt), .preIndex(preIndex), .writeBack(writeBack),
    .addOffset(addOffset), .accSize(accSize), .signedLoad(signedLoad),
    .isStore(isStore), .storeData(storeData), .memRdata(memRdata),
    .misaligned(misaligned), .memAddr(memAddr), .memByteEn(memByteEn),
    .memWrite(memWrite), .memWdata(memWdata), .loadData(loadData),
    .loadValid(loadValid), .baseNew(baseNew), .baseWe(baseWe)
  );

  // R9: request fields hold while memory stalls
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=>
      (memValid && $stable(memAddr) && $stable(memByteEn) &&
       $stable(memWdata) && $stable(memWrite)));

  // R9: base update only with an accepted response
  p_wb_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |-> (memValid && memReady));
endmodule

// File: tb/lsu_unit_test.sv
module lsu_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [31:0] baseVal = '0, regOffset = '0, storeData = '0, memRdata = '0;
  logic [11:0] immOffset = '0;
  logic [1:0]  offSel = '0, accSize = '0;
  logic [4:0]  shiftAmt = '0;
  logic        preIndex = 1'b1, writeBack = 1'b0, addOffset = 1'b1;
  logic        signedLoad = 1'b0, isStore = 1'b0, memReady = 1'b0;
  logic        memValid, memWrite, loadValid, alignFault, baseWe;
  logic [31:0] memAddr, memWdata, loadData, baseNew;
  logic [3:0]  memByteEn;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  lsu_unit uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .baseVal(baseVal), .immOffset(immOffset), .regOffset(regOffset),
    .offSel(offSel), .shiftAmt(shiftAmt), .preIndex(preIndex),
    .writeBack(writeBack), .addOffset(addOffset), .accSize(accSize),
    .signedLoad(signedLoad), .isStore(isStore), .storeData(storeData),
    .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWrite(memWrite), .memWdata(memWdata),
    .memRdata(memRdata), .loadData(loadData), .loadValid(loadValid),
    .alignFault(alignFault), .baseNew(baseNew), .baseWe(baseWe)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-clock protocol model: R9 and R10 relations
  always @(negedge clk) if (rstN) begin
    total++;
    if ((baseWe && !(memValid && memReady)) || (memValid && reqReady)) begin
      bad++;
      $display("FAIL R9/R10 monitor: act=we%0b v%0b r%0b rdy%0b exp=consistent",
               baseWe, memValid, memReady, reqReady);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // issue the request currently on the inputs and model its effects
  task automatic runOp(input int stalls, input logic [31:0] rdata, input bit junk);
    logic [31:0] off, ea, addr, mask, expW, lane, expL;
    int nb, lo;
    bit fault, wb;
    off  = offSel == 2'b00 ? {20'd0, immOffset} :
           offSel == 2'b01 ? regOffset : (regOffset << shiftAmt);
    ea   = addOffset ? baseVal + off : baseVal - off;
    addr = preIndex ? ea : baseVal;
    nb   = accSize == 2'b00 ? 1 : accSize == 2'b01 ? 2 : 4;
    lo   = int'(addr[1:0]);
    fault = (addr % nb) != 0;
    wb   = !preIndex || writeBack;
    mask = '0;
    for (int i = 0; i < nb; i++) mask[8*(lo+i) +: 8] = 8'hFF;
    expW = storeData << (8*lo);
    lane = rdata >> (8*lo);
    if (nb == 1)      expL = {{24{signedLoad & lane[7]}}, lane[7:0]};
    else if (nb == 2) expL = {{16{signedLoad & lane[15]}}, lane[15:0]};
    else              expL = lane;

    @(negedge clk); reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk); reqValid = 1'b0;
    if (fault) begin
      chk(alignFault === 1'b1, "R8 fault pulse", {31'd0, alignFault}, 32'd1);
      chk(memValid === 1'b0, "R8 no request", {31'd0, memValid}, 32'd0);
      chk(reqReady === 1'b1, "R8 ready again", {31'd0, reqReady}, 32'd1);
      @(negedge clk);
      chk(alignFault === 1'b0, "R8 single pulse", {31'd0, alignFault}, 32'd0);
      return;
    end
    chk(alignFault === 1'b0, "R8 no fault", {31'd0, alignFault}, 32'd0);
    chk(memValid === 1'b1, "R9 request valid", {31'd0, memValid}, 32'd1);
    chk(memAddr === addr, "R1/R3/R5 address", memAddr, addr);
    chk(memWrite === isStore, "R6 write flag", {31'd0, memWrite}, {31'd0, isStore});
    if (isStore) begin
      chk(memByteEn === {mask[24], mask[16], mask[8], mask[0]}, "R6 byte enables",
          {28'd0, memByteEn}, {28'd0, mask[24], mask[16], mask[8], mask[0]});
      chk((memWdata & mask) === (expW & mask), "R6 lane data",
          memWdata & mask, expW & mask);
    end
    for (int s = 0; s < stalls; s++) begin
      if (junk) begin
        reqValid = 1'b1; baseVal = 32'hDEAD_0000; isStore = ~isStore;
      end
      #1;
      chk(baseWe === 1'b0, "R9 no early writeback", {31'd0, baseWe}, 32'd0);
      chk(memAddr === addr, "R9/R10 address held", memAddr, addr);
      chk(reqReady === 1'b0, "R10 busy", {31'd0, reqReady}, 32'd0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    memReady = 1'b1; memRdata = rdata;
    #1;
    chk(baseWe === wb, "R3/R4/R5 writeback strobe", {31'd0, baseWe}, {31'd0, wb});
    if (wb) chk(baseNew === ea, "R4/R5 new base", baseNew, ea);
    chk(loadValid === (memWrite == 1'b0), "R7 load valid", {31'd0, loadValid},
        {31'd0, ~memWrite});
    if (!memWrite) chk(loadData === expL, "R7 load data", loadData, expL);
    @(negedge clk); memReady = 1'b0;
    chk(memValid === 1'b0 && reqReady === 1'b1, "R10 single access",
        {30'd0, memValid, reqReady}, 32'd1);
  endtask

  task automatic setOp(input logic [31:0] b, input logic [1:0] sel, input logic [11:0] imm,
                       input logic [31:0] r, input logic [4:0] sh, input bit pre,
                       input bit wbk, input bit add, input logic [1:0] sz,
                       input bit sgn, input bit st, input logic [31:0] d);
    baseVal = b; offSel = sel; immOffset = imm; regOffset = r; shiftAmt = sh;
    preIndex = pre; writeBack = wbk; addOffset = add; accSize = sz;
    signedLoad = sgn; isStore = st; storeData = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(reqReady === 1'b1, "R11 ready", {31'd0, reqReady}, 32'd1);
    chk({memValid, baseWe, loadValid, alignFault} === 4'b0, "R11 outputs idle",
        {28'd0, memValid, baseWe, loadValid, alignFault}, 32'd0);

    // R1 R3 R7: word load, pre-index, immediate add, no writeback
    setOp(32'h200, 2'b00, 12'd12, 0, 0, 1, 0, 1, 2'b10, 0, 0, 0);
    runOp(0, 32'hddccbbaa, 0);
    // R1 R5 R6: word store post-index, subtract 12, writeBack ignored
    setOp(32'h200, 2'b00, 12'd12, 0, 0, 0, 0, 0, 2'b10, 0, 1, 32'h0000_0005);
    runOp(1, 0, 0);
    // R2 R4 R9 R10: shifted register offset with writeback, stalls, junk request
    setOp(32'h1000, 2'b10, 0, 32'd3, 5'd2, 1, 1, 1, 2'b10, 0, 0, 0);
    runOp(3, 32'h1234_5678, 1);
    // R2: unshifted register offset, subtract, post-index
    setOp(32'h400, 2'b01, 12'hFFF, 32'h10, 5'd4, 0, 1, 0, 2'b11, 0, 0, 0);
    runOp(0, 32'hCAFE_F00D, 0);
    // R6: byte stores on lanes 3 and 1, halfword store on upper half
    setOp(32'h200, 2'b00, 12'd3, 0, 0, 1, 0, 1, 2'b00, 0, 1, 32'hAABB_CC77);
    runOp(0, 0, 0);
    setOp(32'h201, 2'b00, 12'd0, 0, 0, 1, 1, 1, 2'b00, 0, 1, 32'h0000_0042);
    runOp(2, 0, 0);
    setOp(32'h200, 2'b00, 12'd2, 0, 0, 1, 0, 1, 2'b01, 0, 1, 32'h1111_BEEF);
    runOp(0, 0, 0);
    // R7: signed and unsigned byte and halfword loads
    setOp(32'h201, 2'b00, 0, 0, 0, 1, 0, 1, 2'b00, 1, 0, 0);
    runOp(0, 32'h1234_8000, 0);
    setOp(32'h201, 2'b00, 0, 0, 0, 1, 0, 1, 2'b00, 0, 0, 0);
    runOp(0, 32'h1234_8000, 0);
    setOp(32'h202, 2'b00, 0, 0, 0, 1, 0, 1, 2'b01, 1, 0, 0);
    runOp(1, 32'h9ABC_0000, 0);
    setOp(32'h202, 2'b00, 0, 0, 0, 1, 0, 1, 2'b01, 0, 0, 0);
    runOp(0, 32'h9ABC_0000, 0);
    setOp(32'h200, 2'b00, 0, 0, 0, 1, 0, 1, 2'b00, 1, 0, 0);
    runOp(0, 32'h0000_007F, 0);
    // R7: signedLoad has no effect on word loads
    setOp(32'h300, 2'b00, 0, 0, 0, 1, 0, 1, 2'b10, 1, 0, 0);
    runOp(0, 32'h8000_0001, 0);
    // R8: misaligned halfword and word, then a good access still works
    setOp(32'h200, 2'b00, 12'd1, 0, 0, 1, 1, 1, 2'b01, 0, 0, 0);
    runOp(0, 0, 0);
    setOp(32'h202, 2'b00, 0, 0, 0, 0, 1, 1, 2'b10, 0, 1, 32'h1);
    runOp(0, 0, 0);
    setOp(32'h200, 2'b00, 12'd4, 0, 0, 1, 1, 1, 2'b10, 0, 0, 0);
    runOp(0, 32'h0102_0304, 0);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule